// File: doc/BRIEF.md
# Parallel Prefix Carry Adder

This block adds two K-bit unsigned operands and a carry-in with no registers in the path. It produces a K-bit sum and a carry-out. Each bit position first forms a generate/propagate pair. A prefix network then merges those pairs into group terms covering bits 0 through i, and every carry comes from its group term together with the carry-in. A final XOR stage turns the carries into sum bits.

One parameter selects the shape of the prefix network:

- **Sparse tree.** An up-sweep followed by a down-sweep. It uses 2K − 2 − log2 K merge cells over 2·log2 K − 1 levels.
- **Dense tree.** Every bit doubles its span at each level. It uses K·log2 K − K + 1 cells over log2 K levels.

Both shapes are built from the same merge cell. That cell always takes the lower-significance pair on its low input, because the merge is associative but not commutative. The block is dropped into a datapath wherever an adder with a short critical path is needed. The integrator picks the shape by trading cell count against depth.

Top module: `pp_adder`

## Requirements
- R1: `sum` equals the low K bits of `op_a + op_b + carry_in`, for any operand values and both carry-in values.
- R2: `carry_out` equals bit K of `op_a + op_b + carry_in`, which is the carry into position K.
- R3: With both operands zero, the output is `{carry_out, sum} = 0` when `carry_in` is 0, and `sum = 1`, `carry_out = 0` when `carry_in` is 1.
- R4: With `op_a` all ones, `op_b` zero and `carry_in` 1, the carry ripples through every position. The result is `sum = 0` and `carry_out = 1`.
- R5: The sparse shape (`TOPO = TOPO_SPARSE`, encoded 0) and the dense shape (`TOPO = TOPO_DENSE`, encoded 1) give identical `sum` and `carry_out` for every input.
- R6: Swapping `op_a` and `op_b` leaves `sum` and `carry_out` unchanged.
- R7: When no position generates a carry (`op_a & op_b == 0`) and `carry_in` is 0, `sum = op_a | op_b` and `carry_out = 0`.
- R8: With both operands all ones, `carry_out` is 1. The sum is all ones with its lowest bit cleared when `carry_in` is 0, and all ones when `carry_in` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | K | First addend |
| op_b | input | K | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | K | Low K bits of the total |
| carry_out | output | 1 | Carry out of bit K−1 |

## Verification
The bench targets full-length carry chains: all ones plus a carry-in, and all ones plus all ones. If a merge cell had its inputs reversed, or a down-sweep node were missing, these chains would break partway and leave a run of wrong sum bits above the break. Alternating patterns with no generate at any position expose a design that leaks a carry where none exists, since it would set a bit that should equal the OR of the operands. Swapped operands, and both shapes driven side by side over random vectors, catch a sum stage or prefix wiring that treats the two operands differently or diverges in only one topology.

// File: rtl/pp_adder_pkg.sv
package pp_adder_pkg;

    typedef enum logic {
        TOPO_SPARSE = 1'b0,
        TOPO_DENSE  = 1'b1
    } topo_e;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Merge a lower-significance span (lo) with the adjacent higher one (hi).
    function automatic gp_t gp_merge(gp_t lo, gp_t hi);
        gp_t res;
        res.g = hi.g | (lo.g & hi.p);
        res.p = lo.p & hi.p;
        return res;
    endfunction

    function automatic int sparse_cells(int k);
        return 2 * k - 2 - $clog2(k);
    endfunction

    function automatic int dense_cells(int k);
        return k * $clog2(k) - k + 1;
    endfunction

endpackage

// File: rtl/pp_merge_cell.sv
module pp_merge_cell
    import pp_adder_pkg::*;
(
    input  gp_t lo_span,
    input  gp_t hi_span,
    output gp_t merged
);
    assign merged = gp_merge(lo_span, hi_span);
endmodule

// File: rtl/pp_bit_gp.sv
module pp_bit_gp
    import pp_adder_pkg::*;
#(
    parameter int K = 16
) (
    input  logic [K-1:0] op_a,
    input  logic [K-1:0] op_b,
    output gp_t  [K-1:0] bit_gp
);
    for (genvar i = 0; i < K; i++) begin : g_bit
        assign bit_gp[i].g = op_a[i] & op_b[i];
        assign bit_gp[i].p = op_a[i] ^ op_b[i];
    end
endmodule

// File: rtl/pp_prefix_tree.sv
module pp_prefix_tree
    import pp_adder_pkg::*;
#(
    parameter int    K    = 16,
    parameter topo_e TOPO = TOPO_SPARSE
) (
    input  gp_t [K-1:0] bit_gp,
    output gp_t [K-1:0] pre_gp
);
    localparam int LG = $clog2(K);

    if (TOPO == TOPO_DENSE) begin : g_dense
        localparam int ROWS = LG + 1;
        gp_t [K-1:0] row [ROWS];

        assign row[0] = bit_gp;

        for (genvar lv = 0; lv < LG; lv++) begin : g_lvl
            localparam int DIST = 1 << lv;
            for (genvar i = 0; i < K; i++) begin : g_node
                if (i >= DIST) begin : g_cell
                    pp_merge_cell u_cell (
                        .lo_span (row[lv][i-DIST]),
                        .hi_span (row[lv][i]),
                        .merged  (row[lv+1][i])
                    );
                end else begin : g_pass
                    assign row[lv+1][i] = row[lv][i];
                end
            end
        end

        assign pre_gp = row[LG];
    end else begin : g_sparse
        localparam int ROWS = 2 * LG;
        gp_t [K-1:0] row [ROWS];

        assign row[0] = bit_gp;

        // Up-sweep: span doubles at each level on the right-most bit of a block.
        for (genvar lv = 0; lv < LG; lv++) begin : g_up
            localparam int DIST = 1 << lv;
            for (genvar i = 0; i < K; i++) begin : g_node
                if (((i + 1) % (2 * DIST)) == 0) begin : g_cell
                    pp_merge_cell u_cell (
                        .lo_span (row[lv][i-DIST]),
                        .hi_span (row[lv][i]),
                        .merged  (row[lv+1][i])
                    );
                end else begin : g_pass
                    assign row[lv+1][i] = row[lv][i];
                end
            end
        end

        // Down-sweep: fill the intermediate positions left incomplete.
        for (genvar dl = 0; dl < LG - 1; dl++) begin : g_down
            localparam int DIST = 1 << (LG - 2 - dl);
            localparam int SRC  = LG + dl;
            for (genvar i = 0; i < K; i++) begin : g_node
                if ((((i + 1) % (2 * DIST)) == DIST) && (i + 1 > DIST)) begin : g_cell
                    pp_merge_cell u_cell (
                        .lo_span (row[SRC][i-DIST]),
                        .hi_span (row[SRC][i]),
                        .merged  (row[SRC+1][i])
                    );
                end else begin : g_pass
                    assign row[SRC+1][i] = row[SRC][i];
                end
            end
        end

        assign pre_gp = row[ROWS-1];
    end
endmodule

// File: rtl/pp_sum_stage.sv
module pp_sum_stage
    import pp_adder_pkg::*;
#(
    parameter int K = 16
) (
    input  gp_t  [K-1:0] bit_gp,
    input  gp_t  [K-1:0] pre_gp,
    input  logic         carry_in,
    output logic [K-1:0] sum,
    output logic         carry_out
);
    logic [K:0] carry;

    assign carry[0] = carry_in;

    for (genvar i = 0; i < K; i++) begin : g_pos
        assign carry[i+1] = pre_gp[i].g | (carry_in & pre_gp[i].p);
        assign sum[i]     = bit_gp[i].p ^ carry[i];
    end

    assign carry_out = carry[K];
endmodule

// File: rtl/pp_adder.sv
module pp_adder
    import pp_adder_pkg::*;
#(
    parameter int    K    = 16,
    parameter topo_e TOPO = TOPO_SPARSE
) (
    input  logic [K-1:0] op_a,
    input  logic [K-1:0] op_b,
    input  logic         carry_in,
    output logic [K-1:0] sum,
    output logic         carry_out
);
    gp_t [K-1:0] bit_gp;
    gp_t [K-1:0] pre_gp;

    pp_bit_gp #(.K(K)) u_bits (
        .op_a   (op_a),
        .op_b   (op_b),
        .bit_gp (bit_gp)
    );

    pp_prefix_tree #(.K(K), .TOPO(TOPO)) u_tree (
        .bit_gp (bit_gp),
        .pre_gp (pre_gp)
    );

    pp_sum_stage #(.K(K)) u_sum (
        .bit_gp    (bit_gp),
        .pre_gp    (pre_gp),
        .carry_in  (carry_in),
        .sum       (sum),
        .carry_out (carry_out)
    );
endmodule

// File: rtl/pp_adder_chk.sv
module pp_adder_chk #(
    parameter int K = 16
) (
    input logic [K-1:0] op_a,
    input logic [K-1:0] op_b,
    input logic         carry_in,
    input logic [K-1:0] sum,
    input logic         carry_out
);
    logic [K:0] total;
    assign total = {1'b0, op_a} + {1'b0, op_b} + {{K{1'b0}}, carry_in};

    always_comb begin
        p_sum_r1: assert (sum == total[K-1:0])
            else $error("sum mismatch");
        p_cout_r2: assert (carry_out == total[K])
            else $error("carry_out mismatch");
        if (op_a == '0 && op_b == '0) begin
            p_zero_r3: assert ({carry_out, sum} == {{K{1'b0}}, carry_in})
                else $error("zero operands wrong");
        end
        if (op_a == '1 && op_b == '0 && carry_in) begin
            p_ripple_r4: assert (carry_out && sum == '0)
                else $error("full ripple wrong");
        end
        if ((op_a & op_b) == '0 && !carry_in) begin
            p_nogen_r7: assert (!carry_out && sum == (op_a | op_b))
                else $error("spurious carry");
        end
        if (op_a == '1 && op_b == '1) begin
            p_ones_r8: assert (carry_out && sum == {{(K-1){1'b1}}, carry_in})
                else $error("all-ones sum wrong");
        end
    end
endmodule

bind pp_adder pp_adder_chk #(.K(K)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
);

// File: tb/pp_adder_test.sv
module pp_adder_test;
    import pp_adder_pkg::*;

    localparam int K = 16;
    localparam int WATCHDOG_CYCLES = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [K-1:0] op_a = '0;
    logic [K-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [K-1:0] sum_sp, sum_dn;
    logic         co_sp, co_dn;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pp_adder #(.K(K), .TOPO(TOPO_SPARSE)) uut (
        .op_a (op_a), .op_b (op_b), .carry_in (carry_in),
        .sum (sum_sp), .carry_out (co_sp)
    );

    pp_adder #(.K(K), .TOPO(TOPO_DENSE)) uut_dense (
        .op_a (op_a), .op_b (op_b), .carry_in (carry_in),
        .sum (sum_dn), .carry_out (co_dn)
    );

    function automatic logic [K:0] ref_add(logic [K-1:0] a, logic [K-1:0] b, logic c);
        return {1'b0, a} + {1'b0, b} + {{K{1'b0}}, c};
    endfunction

    task automatic check(string tag, logic [K:0] got, logic [K:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h cin=%b)",
                     tag, got, exp, op_a, op_b, carry_in);
        end
    endtask

    task automatic apply(logic [K-1:0] a, logic [K-1:0] b, logic c);
        @(posedge clk);
        op_a     = a;
        op_b     = b;
        carry_in = c;
        @(negedge clk);
    endtask

    task automatic check_both(string tag, logic [K:0] exp);
        check({tag, " sparse"}, {co_sp, sum_sp}, exp);
        check({tag, " dense"},  {co_dn, sum_dn}, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [K:0] first;
        void'($urandom(32'h5eed_0c4a));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R3: reset-state inputs are zero, result zero
        check_both("R3 reset state", '0);
        apply('0, '0, 1'b1);
        check_both("R3 zero plus carry", {{K{1'b0}}, 1'b1});

        // R4: carry ripples through every position
        apply('1, '0, 1'b1);
        check_both("R4 ones plus carry", {1'b1, {K{1'b0}}});
        apply('0, '1, 1'b1);
        check_both("R4 ones plus carry swapped", {1'b1, {K{1'b0}}});

        // R8: all ones plus all ones
        apply('1, '1, 1'b0);
        check_both("R8 ones+ones cin0", {1'b1, {(K-1){1'b1}}, 1'b0});
        apply('1, '1, 1'b1);
        check_both("R8 ones+ones cin1", {1'b1, {K{1'b1}}});

        // R7: no generate anywhere
        apply({(K/2){2'b10}}, {(K/2){2'b01}}, 1'b0);
        check_both("R7 alternating", {1'b0, {K{1'b1}}});
        apply({(K/4){4'b1100}}, {(K/4){4'b0010}}, 1'b0);
        check_both("R7 sparse bits", {1'b0, {(K/4){4'b1110}}});

        // R1/R2: walking single carry into each position
        for (int j = 0; j < K; j++) begin
            logic [K-1:0] a = ({K{1'b1}} >> (K - 1 - j));
            apply(a, {{(K-1){1'b0}}, 1'b1}, 1'b0);
            check_both("R1 R2 walking carry", ref_add(a, {{(K-1){1'b0}}, 1'b1}, 1'b0));
        end

        // Random vectors: R1, R2, R5, R6
        for (int n = 0; n < 400; n++) begin
            logic [K-1:0] a = K'($urandom);
            logic [K-1:0] b = K'($urandom);
            logic         c = 1'($urandom);
            apply(a, b, c);
            check("R1 R2 random sparse", {co_sp, sum_sp}, ref_add(a, b, c));
            check("R1 R2 random dense",  {co_dn, sum_dn}, ref_add(a, b, c));
            check("R5 shapes agree", {co_dn, sum_dn}, {co_sp, sum_sp});
            first = {co_sp, sum_sp};
            apply(b, a, c);
            check("R6 swapped operands", {co_sp, sum_sp}, first);
        end

        finish_run();
    end
endmodule